// File: doc/BRIEF.md
# Sync-Referenced Clamp and Horizontal Sync Regenerator

This block sits in the pixel-clock domain of a video capture front end. It takes a raw horizontal sync line and brings it into the clock domain through a two-flop synchroniser. It then converts the line to an active-high form using a configurable input polarity and detects its leading and trailing edges. Each trailing edge starts a clamp pulse after a programmable delay counted in pixel clocks, and the clamp lasts a programmable number of clocks. Each leading edge starts a regenerated horizontal sync pulse of programmable width with a selectable output level. A raw vertical sync passes straight through, with optional inversion.

The clamp output can also come from an external clamp pin, passed through without change. All settings are plain parallel inputs that are held stable while lines are running. The suggested power-up settings are: placement 128, clamp length 128, sync width 32, input polarity active high, output pulse active high, vertical sync inverted. No pin carries a data stream, so the block has no valid/ready handshake and cannot be stalled.

After reset, edge detection stays disabled until the synchroniser holds real samples. A change of input polarity can create one false edge, so it should be made between lines.

Top module: `hsync_clamp_gen`

## Requirements
- R1: With `cfg_hs_in_pol`=1 a high level on `hs_raw` is the active sync level; with 0 a low level is. An edge of the active-high form is acted on 3 clocks after the pin changes (two synchroniser flops plus one timer register).
- R2: The internal clamp rises P clocks after the earliest possible start, where P is `cfg_clamp_place`. Counting the posedges after `hs_raw` goes inactive, the clamp is first high after posedge 3+P. P=0 starts it on the first clock after the trailing edge is detected.
- R3: The internal clamp stays high for exactly `cfg_clamp_len` clocks. A length of 0 gives no clamp pulse.
- R4: The regenerated sync is active for exactly `cfg_hs_width` clocks and is first active after the 3rd posedge following the leading edge on `hs_raw`. A width of 0 gives no pulse.
- R5: With `cfg_hs_out_pol`=0 the sync output is high while active and low otherwise; with 1 the levels are swapped.
- R6: With `cfg_clamp_src`=1 `clamp_o` follows `clamp_ext` in the same cycle. With 0 it carries the internal sync-derived clamp.
- R7: With `cfg_vs_keep`=0 `vs_o` is the inverse of `vs_raw`; with 1 it equals `vs_raw`, with no clock delay.
- R8: A new trailing edge restarts clamp placement and duration, dropping any clamp still pending or running from the earlier edge.
- R9: After reset the internal clamp is low and the regenerated sync sits at its inactive level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hs_raw | input | 1 | Raw horizontal sync, asynchronous |
| vs_raw | input | 1 | Raw vertical sync |
| clamp_ext | input | 1 | External clamp input |
| cfg_clamp_place | input | 8 | Clocks from the trailing edge to the clamp start |
| cfg_clamp_len | input | 8 | Clamp length in clocks |
| cfg_hs_width | input | 8 | Regenerated sync width in clocks |
| cfg_hs_in_pol | input | 1 | 1: input sync active high, 0: active low |
| cfg_clamp_src | input | 1 | 0: internal clamp, 1: external clamp |
| cfg_hs_out_pol | input | 1 | 0: active-high output, 1: active-low output |
| cfg_vs_keep | input | 1 | 0: invert vertical sync, 1: pass unchanged |
| clamp_o | output | 1 | Clamp pulse |
| hs_o | output | 1 | Regenerated horizontal sync |
| vs_o | output | 1 | Vertical sync output |

## Verification
The embedded assertions check, on every cycle, the following properties:
- a zero length never produces a pulse;
- a zero placement starts the clamp at once;
- a pulse only rises out of a trigger or a finished wait;
- the external clamp route and the idle output level hold.

Exact arithmetic positions and lengths can only be shown by the bench's line scenarios:
- clamp start at 3+P after the trailing edge, for several placements and lengths;
- sync width under both polarities;
- restart when a second line arrives early.

// File: rtl/hcg_pkg.sv
package hcg_pkg;
  typedef enum logic [1:0] {
    TMR_IDLE   = 2'd0,
    TMR_WAIT   = 2'd1,
    TMR_ACTIVE = 2'd2
  } tmr_state_e;
endpackage

// File: rtl/hcg_sync_edge.sv
module hcg_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_i,
  input  logic act_high_i,
  output logic rise_o,
  output logic fall_o
);
  localparam int VW = STAGES + 1;

  logic [STAGES-1:0] sh_q;
  logic [VW-1:0]     vld_q;
  logic              norm_w;
  logic              prev_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= raw_i;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= {sh_q[STAGES-2:0], raw_i};
      end
    end
  endgenerate

  // edges stay masked until the synchroniser holds real samples
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= '0;
    else        vld_q <= {vld_q[VW-2:0], 1'b1};
  end

  assign norm_w = act_high_i ? sh_q[STAGES-1] : ~sh_q[STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= norm_w;
  end

  assign rise_o = vld_q[VW-1] &  norm_w & ~prev_q;
  assign fall_o = vld_q[VW-1] & ~norm_w &  prev_q;

  AST_EDGE_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_o || fall_o) |-> $past(rst_n)) else $error("edge right after reset"); // R1
endmodule

// File: rtl/hcg_pulse_timer.sv
module hcg_pulse_timer
  import hcg_pkg::*;
#(
  parameter int CW        = 8,
  parameter bit USE_DELAY = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          trig_i,
  input  logic [CW-1:0] delay_i,
  input  logic [CW-1:0] len_i,
  output logic          pulse_o
);
  localparam logic [CW-1:0] ONE = CW'(1);

  tmr_state_e    st_q;
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] dly_w;

  generate
    if (USE_DELAY) begin : g_dly
      assign dly_w = delay_i;
    end else begin : g_nodly
      assign dly_w = '0;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= TMR_IDLE;
      cnt_q <= '0;
    end else if (trig_i) begin
      if (dly_w != '0) begin
        st_q  <= TMR_WAIT;
        cnt_q <= dly_w;
      end else if (len_i != '0) begin
        st_q  <= TMR_ACTIVE;
        cnt_q <= len_i;
      end else begin
        st_q  <= TMR_IDLE;
        cnt_q <= '0;
      end
    end else begin
      unique case (st_q)
        TMR_WAIT: begin
          if (cnt_q == ONE) begin
            if (len_i != '0) begin
              st_q  <= TMR_ACTIVE;
              cnt_q <= len_i;
            end else begin
              st_q  <= TMR_IDLE;
              cnt_q <= '0;
            end
          end else begin
            cnt_q <= cnt_q - ONE;
          end
        end
        TMR_ACTIVE: begin
          if (cnt_q == ONE) begin
            st_q  <= TMR_IDLE;
            cnt_q <= '0;
          end else begin
            cnt_q <= cnt_q - ONE;
          end
        end
        default: begin
          st_q  <= TMR_IDLE;
          cnt_q <= '0;
        end
      endcase
    end
  end

  assign pulse_o = (st_q == TMR_ACTIVE);

  AST_ZERO_LEN_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_i && len_i == '0) |=> !pulse_o) else $error("zero length pulsed"); // R3
  AST_ZERO_PLACE_START: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_i && dly_w == '0 && len_i != '0) |=> pulse_o) else $error("no immediate start"); // R2
  AST_RISE_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pulse_o) |-> ($past(trig_i) || $past(st_q == TMR_WAIT))) else $error("uncaused pulse"); // R8
endmodule

// File: rtl/hsync_clamp_gen.sv
module hsync_clamp_gen #(
  parameter int CFG_W     = 8,
  parameter int SYNC_STGS = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hs_raw,
  input  logic             vs_raw,
  input  logic             clamp_ext,
  input  logic [CFG_W-1:0] cfg_clamp_place,
  input  logic [CFG_W-1:0] cfg_clamp_len,
  input  logic [CFG_W-1:0] cfg_hs_width,
  input  logic             cfg_hs_in_pol,
  input  logic             cfg_clamp_src,
  input  logic             cfg_hs_out_pol,
  input  logic             cfg_vs_keep,
  output logic             clamp_o,
  output logic             hs_o,
  output logic             vs_o
);
  logic lead_w, trail_w;
  logic clamp_int_w, hs_act_w;

  hcg_sync_edge #(.STAGES(SYNC_STGS)) u_edge (
    .clk       (clk),
    .rst_n     (rst_n),
    .raw_i     (hs_raw),
    .act_high_i(cfg_hs_in_pol),
    .rise_o    (lead_w),
    .fall_o    (trail_w)
  );

  hcg_pulse_timer #(.CW(CFG_W), .USE_DELAY(1'b1)) u_clamp_tmr (
    .clk    (clk),
    .rst_n  (rst_n),
    .trig_i (trail_w),
    .delay_i(cfg_clamp_place),
    .len_i  (cfg_clamp_len),
    .pulse_o(clamp_int_w)
  );

  hcg_pulse_timer #(.CW(CFG_W), .USE_DELAY(1'b0)) u_hs_tmr (
    .clk    (clk),
    .rst_n  (rst_n),
    .trig_i (lead_w),
    .delay_i('0),
    .len_i  (cfg_hs_width),
    .pulse_o(hs_act_w)
  );

  assign clamp_o = cfg_clamp_src ? clamp_ext : clamp_int_w;
  assign hs_o    = hs_act_w ^ cfg_hs_out_pol;
  assign vs_o    = cfg_vs_keep ? vs_raw : ~vs_raw;

  AST_HS_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    !hs_act_w |-> (hs_o == cfg_hs_out_pol)) else $error("hs idle level"); // R5
  AST_EXT_CLAMP: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_clamp_src |-> (clamp_o == clamp_ext)) else $error("ext clamp route"); // R6
endmodule

// File: tb/hsync_clamp_gen_bench.sv
module hsync_clamp_gen_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hs_raw = 1'b0, vs_raw = 1'b0, clamp_ext = 1'b0;
  logic [7:0] cfg_clamp_place = 8'd128, cfg_clamp_len = 8'd128, cfg_hs_width = 8'd32;
  logic cfg_hs_in_pol = 1'b1, cfg_clamp_src = 1'b0, cfg_hs_out_pol = 1'b0, cfg_vs_keep = 1'b0;
  logic clamp_o, hs_o, vs_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hsync_clamp_gen u_hsync_clamp_gen (
    .clk(clk), .rst_n(rst_n), .hs_raw(hs_raw), .vs_raw(vs_raw), .clamp_ext(clamp_ext),
    .cfg_clamp_place(cfg_clamp_place), .cfg_clamp_len(cfg_clamp_len),
    .cfg_hs_width(cfg_hs_width), .cfg_hs_in_pol(cfg_hs_in_pol),
    .cfg_clamp_src(cfg_clamp_src), .cfg_hs_out_pol(cfg_hs_out_pol),
    .cfg_vs_keep(cfg_vs_keep), .clamp_o(clamp_o), .hs_o(hs_o), .vs_o(vs_o)
  );

  task automatic check(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  // one sync line: active for h clocks, then observed until all pulses end
  task automatic run_line(input int h, input int p, input int l, input int w,
                          input bit ipol, input bit opol);
    int n, c_first, c_cnt, h_first, h_cnt;
    @(negedge clk);
    if (ipol != cfg_hs_in_pol) begin
      cfg_hs_in_pol = ipol;
      hs_raw = ~ipol;
      repeat (600) @(negedge clk);
    end
    hs_raw = ~ipol;
    cfg_clamp_place = 8'(p); cfg_clamp_len = 8'(l);
    cfg_hs_width = 8'(w); cfg_hs_out_pol = opol;
    repeat (4) @(negedge clk);
    hs_raw = ipol;
    n = ((h + p + l) > w ? (h + p + l) : w) + 12;
    c_first = -1; c_cnt = 0; h_first = -1; h_cnt = 0;
    for (int i = 1; i <= n; i++) begin
      @(posedge clk); @(negedge clk);
      if (clamp_o) begin c_cnt++; if (c_first < 0) c_first = i; end
      if (hs_o != opol) begin h_cnt++; if (h_first < 0) h_first = i; end
      if (i == h) hs_raw = ~ipol;
    end
    check("R2 clamp start", c_first, (l == 0) ? -1 : h + 3 + p);
    check("R3 clamp length", c_cnt, l);
    check("R4 hs start", h_first, (w == 0) ? -1 : 3);
    check(ipol ? "R4 hs width" : "R1 hs width active-low in", h_cnt, w);
    check("R5 hs idle level", int'(hs_o), int'(opol));
  endtask

  initial begin
    int pv[4];
    int lv[4];
    int wv[3];
    int c_first, c_cnt;
    pv = '{0, 1, 7, 255};
    lv = '{0, 1, 4, 255};
    wv = '{0, 3, 255};
    repeat (3) @(negedge clk);
    // R9: reset state
    check("R9 clamp in reset", int'(clamp_o), 0);
    check("R9 hs in reset", int'(hs_o), 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check("R9 clamp after reset", int'(clamp_o), 0);
    check("R9 hs after reset", int'(hs_o), 0);

    // sweep: placement x length x width x polarities
    for (int ip = 1; ip >= 0; ip--)
      for (int a = 0; a < 4; a++)
        for (int b = 0; b < 4; b++)
          for (int c = 0; c < 3; c++)
            run_line((c == 1) ? 1 : 6, pv[a], lv[b], wv[c], ip[0], a[0]);

    // R8: second trailing edge restarts a pending clamp
    @(negedge clk);
    cfg_hs_in_pol = 1'b1; hs_raw = 1'b0;
    cfg_clamp_place = 8'd20; cfg_clamp_len = 8'd5; cfg_hs_width = 8'd1;
    repeat (600) @(negedge clk);
    hs_raw = 1'b1;
    c_first = -1; c_cnt = 0;
    for (int i = 1; i <= 60; i++) begin
      @(posedge clk); @(negedge clk);
      if (clamp_o) begin c_cnt++; if (c_first < 0) c_first = i; end
      if (i == 2) hs_raw = 1'b0;
      if (i == 6) hs_raw = 1'b1;
      if (i == 8) hs_raw = 1'b0;
    end
    check("R8 restart start", c_first, 8 + 3 + 20);
    check("R8 single clamp length", c_cnt, 5);

    // R6: external clamp source
    cfg_clamp_src = 1'b1;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk); clamp_ext = k[0]; #1;
      check("R6 ext clamp follow", int'(clamp_o), k & 1);
    end
    clamp_ext = 1'b0; cfg_clamp_src = 1'b0; #1;
    check("R6 internal clamp back", int'(clamp_o), 0);

    // R7: vertical sync path
    for (int k = 0; k < 4; k++) begin
      @(negedge clk); cfg_vs_keep = k[1]; vs_raw = k[0]; #1;
      check("R7 vs out", int'(vs_o), k[1] ? (k & 1) : ((k & 1) ^ 1));
    end
    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule